// File: doc/BRIEF.md
# Memory-Mapped SPI Flash Access Sequencer

This block sits between a simple bus slave port and a byte-wide SPI shifter. It turns loads and stores that land in a flash window into SPI byte streams for one of several serial flash devices. Each device has its own active-low select line. A framed window access wraps the data in an opcode and an address. A raw access passes bytes through untouched, so software can build any command by hand.

Each select has its own control word with three fields: an opcode, a two-bit access mode and a select-release bit. Two shared words hold the per-select write permissions and the per-select address lengths. A register access completes on the next cycle. A window access holds back the ready pulse until its last SPI byte has come back and the select line has been released. Write gating and mode decode are checked once, when the request is accepted. An access that fails either check finishes at once, sends nothing on the SPI side and returns zero.

Top module: `flash_window_seq`

## Requirements
- R1: After reset every `cs_n` line is high. Reading control word i (offset 0x10 + 4*i) returns 0x0000_0004. The permission word (offset 0x00) and the address-length word (offset 0x04) both read 0.
- R2: The mode field is bits [1:0] of a control word: 0 plain read, 1 fast read, 2 program, 3 raw. Plain read always sends opcode 0x03. Fast read and program send control bits [23:16].
- R3: A framed access drives the selected `cs_n` low before its first byte. It then sends the opcode, the address bytes from most significant down, and the data bytes. `cs_n` returns high only after the last byte has completed, and it stays low for every byte in between.
- R4: The address is 4 bytes when bit i of the address-length word is set for select i, and 3 bytes when it is clear.
- R5: `req_size` holds the byte count minus one (1 to 4 bytes). Data byte d moves on bits [8d+7:8d], and byte 0 goes first.
- R6: In raw mode, a read clocks out 0x00 for each byte and assembles the returned bytes into the read data. A write sends only the data bytes. No opcode or address is added, and `cs_n` is left as software set it.
- R7: Bit 2 of control word i is the release bit, and it drives `cs_n[i]` directly. A register write changes the line by the cycle in which its ready pulse is seen.
- R8: A window write to select i is dropped, with no SPI bytes, unless bit 16+i of the permission word is set. This holds in every mode.
- R9: A write in plain-read or fast-read mode, or a read in program mode, is refused and sends no SPI bytes.
- R10: `req_ready` is a single-cycle pulse. For a framed access it does not come before `cs_n` has returned high. A dropped or refused access completes with read data 0.
- R11: `xfer_go` is a single-cycle pulse. A new byte is issued only after `xfer_done` has returned the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held with its fields until `req_ready` |
| req_window | input | 1 | 1 = flash window access, 0 = register access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cs | input | CSW | Select index for window accesses |
| req_size | input | 2 | Byte count minus one |
| req_addr | input | AW | Window byte offset, or register offset in bits [7:2] |
| req_wdata | input | 32 | Write data, least significant byte first |
| req_ready | output | 1 | Completion pulse |
| req_rdata | output | 32 | Read data, valid with `req_ready` |
| xfer_go | output | 1 | Start one SPI byte |
| xfer_tx | output | 8 | Byte to shift out |
| xfer_done | input | 1 | Byte exchange finished |
| xfer_rx | input | 8 | Byte shifted in |
| cs_n | output | NCS | Active-low select lines |

## Verification
The checker runs on every cycle and covers the pulse shape of `xfer_go` and `req_ready`. It checks that the select line stays low for every byte of a framed access. It checks that no byte of a window write leaves without the write permission, and that a control write has moved its select line by the time ready is seen. Only the bench scenarios can show the rest: the exact order and values of the opcode, address and data bytes, the 3- versus 4-byte choice, the fixed read opcode, how raw-mode reads are assembled, and that refused accesses send nothing and return zero.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  typedef enum logic [1:0] {
    MODE_RD  = 2'd0,
    MODE_FRD = 2'd1,
    MODE_WR  = 2'd2,
    MODE_RAW = 2'd3
  } acc_mode_e;

  typedef struct packed {
    logic [7:0] opcode;
    logic       release_n;
    acc_mode_e  mode;
  } sel_ctrl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSON,
    ST_LOAD,
    ST_WAIT,
    ST_CSOFF
  } seq_state_e;

  localparam logic [7:0] OPC_SLOW_READ = 8'h03;
  localparam int         CTRL_OPC_LSB  = 16;
  localparam int         CTRL_REL_BIT  = 2;
  localparam int         PERM_LSB      = 16;
  localparam int         IDX_PERM      = 0;
  localparam int         IDX_ALEN      = 1;
  localparam int         IDX_CTRL0     = 4;

endpackage

// File: rtl/flash_seq_regs.sv
module flash_seq_regs
  import flash_seq_pkg::*;
#(
  parameter int NCS    = 5,
  parameter int CSW    = 3,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [CSW-1:0]    seq_sel,
  input  logic              seq_rel_clr,
  input  logic              seq_rel_set,
  output logic [7:0]        opc_arr  [NCS],
  output acc_mode_e         mode_arr [NCS],
  output logic [NCS-1:0]    perm_vec,
  output logic [NCS-1:0]    alen_vec,
  output logic [NCS-1:0]    cs_n
);

  sel_ctrl_t ctrl_q [NCS];
  logic      unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      perm_vec <= '0;
      alen_vec <= '0;
    end else if (wr_en) begin
      if (idx == IDX_W'(IDX_PERM)) perm_vec <= wr_data[PERM_LSB +: NCS];
      if (idx == IDX_W'(IDX_ALEN)) alen_vec <= wr_data[NCS-1:0];
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_sel
    always_ff @(posedge clk) begin
      if (rst) begin
        ctrl_q[i].opcode    <= '0;
        ctrl_q[i].release_n <= 1'b1;
        ctrl_q[i].mode      <= MODE_RD;
      end else if (wr_en && idx == IDX_W'(IDX_CTRL0 + i)) begin
        ctrl_q[i].opcode    <= wr_data[CTRL_OPC_LSB +: 8];
        ctrl_q[i].release_n <= wr_data[CTRL_REL_BIT];
        ctrl_q[i].mode      <= acc_mode_e'(wr_data[1:0]);
      end else if (seq_sel == CSW'(i) && seq_rel_clr) begin
        ctrl_q[i].release_n <= 1'b0;
      end else if (seq_sel == CSW'(i) && seq_rel_set) begin
        ctrl_q[i].release_n <= 1'b1;
      end
    end
    assign opc_arr[i]  = ctrl_q[i].opcode;
    assign mode_arr[i] = ctrl_q[i].mode;
    assign cs_n[i]     = ctrl_q[i].release_n;
  end

  always_comb begin
    rd_data = '0;
    if (idx == IDX_W'(IDX_PERM)) rd_data[PERM_LSB +: NCS] = perm_vec;
    if (idx == IDX_W'(IDX_ALEN)) rd_data[NCS-1:0] = alen_vec;
    for (int i = 0; i < NCS; i++) begin
      if (idx == IDX_W'(IDX_CTRL0 + i))
        rd_data = {8'h00, ctrl_q[i].opcode, 13'h0000, ctrl_q[i].release_n, ctrl_q[i].mode};
    end
  end

endmodule

// File: rtl/flash_seq_frame.sv
module flash_seq_frame #(
  parameter int AW = 32
) (
  input  logic [3:0]    k,
  input  logic          framed,
  input  logic          alen4,
  input  logic [1:0]    size_m1,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          is_write,
  output logic [3:0]    hdr_len,
  output logic [3:0]    last_k,
  output logic          in_data,
  output logic [1:0]    data_idx,
  output logic [7:0]    tx_byte
);

  logic [3:0] alen_n;
  logic [1:0] addr_sel;
  logic [7:0] addr_byte;
  logic [7:0] data_byte;

  always_comb begin
    alen_n    = alen4 ? 4'd4 : 4'd3;
    hdr_len   = framed ? (alen_n + 4'd1) : 4'd0;
    last_k    = hdr_len + {2'b00, size_m1};
    in_data   = (k >= hdr_len);
    data_idx  = 2'(k - hdr_len);
    addr_sel  = 2'(alen_n - k);
    addr_byte = 8'(addr >> {addr_sel, 3'b000});
    data_byte = is_write ? 8'(wdata >> {data_idx, 3'b000}) : 8'h00;
    if (in_data)       tx_byte = data_byte;
    else if (k == '0)  tx_byte = opcode;
    else               tx_byte = addr_byte;
  end

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
  import flash_seq_pkg::*;
#(
  parameter int NCS = 5,
  parameter int CSW = 3,
  parameter int AW  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_window,
  input  logic            req_write,
  input  logic [CSW-1:0]  req_cs,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [31:0]     req_wdata,
  output logic            req_ready,
  output logic [31:0]     req_rdata,
  input  logic [31:0]     reg_rdata,
  output logic            reg_wr_en,
  input  logic [7:0]      opc_arr  [NCS],
  input  acc_mode_e       mode_arr [NCS],
  input  logic [NCS-1:0]  perm_vec,
  input  logic [NCS-1:0]  alen_vec,
  output logic [CSW-1:0]  sel_q,
  output logic            rel_clr,
  output logic            rel_set,
  output logic [3:0]      k_q,
  output logic            framed_q,
  output logic            alen4_q,
  output logic [1:0]      size_q,
  output logic [7:0]      opc_q,
  output logic [AW-1:0]   addr_q,
  output logic [31:0]     wdata_q,
  output logic            write_q,
  input  logic [3:0]      last_k,
  input  logic            in_data,
  input  logic [1:0]      data_idx,
  input  logic [7:0]      tx_byte,
  output logic            xfer_go,
  output logic [7:0]      xfer_tx,
  input  logic            xfer_done,
  input  logic [7:0]      xfer_rx
);

  seq_state_e state_q;
  logic       accept;
  logic       cs_ok;
  acc_mode_e  cur_mode;
  logic       cur_perm;
  logic       go_raw;
  logic       go_framed;

  assign accept    = (state_q == ST_IDLE) && req_valid && !req_ready;
  assign reg_wr_en = accept && !req_window && req_write;
  assign rel_clr   = (state_q == ST_CSON);
  assign rel_set   = (state_q == ST_CSOFF);

  always_comb begin
    cs_ok    = (int'(req_cs) < NCS);
    cur_mode = MODE_RD;
    cur_perm = 1'b0;
    for (int i = 0; i < NCS; i++) begin
      if (req_cs == CSW'(i)) begin
        cur_mode = mode_arr[i];
        cur_perm = perm_vec[i];
      end
    end
    go_raw    = cs_ok && (cur_mode == MODE_RAW) && (!req_write || cur_perm);
    go_framed = cs_ok && (req_write ? (cur_mode == MODE_WR && cur_perm)
                                    : (cur_mode == MODE_RD || cur_mode == MODE_FRD));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      req_ready <= 1'b0;
      req_rdata <= '0;
      xfer_go   <= 1'b0;
      xfer_tx   <= '0;
      k_q       <= '0;
      sel_q     <= '0;
      framed_q  <= 1'b0;
      alen4_q   <= 1'b0;
      size_q    <= '0;
      opc_q     <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      write_q   <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      xfer_go   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            req_rdata <= '0;
            if (!req_window) begin
              if (!req_write) req_rdata <= reg_rdata;
              req_ready <= 1'b1;
            end else if (go_raw || go_framed) begin
              k_q      <= '0;
              sel_q    <= req_cs;
              framed_q <= go_framed;
              alen4_q  <= |(alen_vec & (NCS'(1) << req_cs));
              size_q   <= req_size;
              opc_q    <= OPC_SLOW_READ;
              for (int i = 0; i < NCS; i++)
                if (req_cs == CSW'(i) && cur_mode != MODE_RD) opc_q <= opc_arr[i];
              addr_q   <= req_addr;
              wdata_q  <= req_wdata;
              write_q  <= req_write;
              state_q  <= go_framed ? ST_CSON : ST_LOAD;
            end else begin
              req_ready <= 1'b1;
            end
          end
        end
        ST_CSON: state_q <= ST_LOAD;
        ST_LOAD: begin
          xfer_go <= 1'b1;
          xfer_tx <= tx_byte;
          state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (xfer_done) begin
            if (in_data && !write_q) req_rdata[{data_idx, 3'b000} +: 8] <= xfer_rx;
            if (k_q == last_k) begin
              if (framed_q) begin
                state_q <= ST_CSOFF;
              end else begin
                req_ready <= 1'b1;
                state_q   <= ST_IDLE;
              end
            end else begin
              k_q     <= k_q + 4'd1;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_CSOFF: begin
          req_ready <= 1'b1;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/flash_window_seq.sv
module flash_window_seq
  import flash_seq_pkg::*;
#(
  parameter int NCS = 5,
  parameter int AW  = 32,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_window,
  input  logic            req_write,
  input  logic [CSW-1:0]  req_cs,
  input  logic [1:0]      req_size,
  input  logic [AW-1:0]   req_addr,
  input  logic [31:0]     req_wdata,
  output logic            req_ready,
  output logic [31:0]     req_rdata,
  output logic            xfer_go,
  output logic [7:0]      xfer_tx,
  input  logic            xfer_done,
  input  logic [7:0]      xfer_rx,
  output logic [NCS-1:0]  cs_n
);

  localparam int IDX_W = 6;

  logic [31:0]    reg_rdata;
  logic           reg_wr_en;
  logic [7:0]     opc_arr  [NCS];
  acc_mode_e      mode_arr [NCS];
  logic [NCS-1:0] perm_vec;
  logic [NCS-1:0] alen_vec;
  logic [CSW-1:0] seq_sel;
  logic           rel_clr;
  logic           rel_set;
  logic [3:0]     k_q;
  logic           seq_framed;
  logic           alen4_q;
  logic [1:0]     size_q;
  logic [7:0]     opc_q;
  logic [AW-1:0]  addr_q;
  logic [31:0]    wdata_q;
  logic           write_q;
  logic [3:0]     hdr_len;
  logic [3:0]     last_k;
  logic           in_data;
  logic [1:0]     data_idx;
  logic [7:0]     tx_byte;
  logic           unused_hdr;

  assign unused_hdr = ^hdr_len;

  flash_seq_regs #(.NCS(NCS), .CSW(CSW), .IDX_W(IDX_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (reg_wr_en),
    .idx         (req_addr[IDX_W+1:2]),
    .wr_data     (req_wdata),
    .rd_data     (reg_rdata),
    .seq_sel     (seq_sel),
    .seq_rel_clr (rel_clr),
    .seq_rel_set (rel_set),
    .opc_arr     (opc_arr),
    .mode_arr    (mode_arr),
    .perm_vec    (perm_vec),
    .alen_vec    (alen_vec),
    .cs_n        (cs_n)
  );

  flash_seq_frame #(.AW(AW)) u_frame (
    .k        (k_q),
    .framed   (seq_framed),
    .alen4    (alen4_q),
    .size_m1  (size_q),
    .opcode   (opc_q),
    .addr     (addr_q),
    .wdata    (wdata_q),
    .is_write (write_q),
    .hdr_len  (hdr_len),
    .last_k   (last_k),
    .in_data  (in_data),
    .data_idx (data_idx),
    .tx_byte  (tx_byte)
  );

  flash_seq_ctrl #(.NCS(NCS), .CSW(CSW), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_window (req_window),
    .req_write  (req_write),
    .req_cs     (req_cs),
    .req_size   (req_size),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_ready  (req_ready),
    .req_rdata  (req_rdata),
    .reg_rdata  (reg_rdata),
    .reg_wr_en  (reg_wr_en),
    .opc_arr    (opc_arr),
    .mode_arr   (mode_arr),
    .perm_vec   (perm_vec),
    .alen_vec   (alen_vec),
    .sel_q      (seq_sel),
    .rel_clr    (rel_clr),
    .rel_set    (rel_set),
    .k_q        (k_q),
    .framed_q   (seq_framed),
    .alen4_q    (alen4_q),
    .size_q     (size_q),
    .opc_q      (opc_q),
    .addr_q     (addr_q),
    .wdata_q    (wdata_q),
    .write_q    (write_q),
    .last_k     (last_k),
    .in_data    (in_data),
    .data_idx   (data_idx),
    .tx_byte    (tx_byte),
    .xfer_go    (xfer_go),
    .xfer_tx    (xfer_tx),
    .xfer_done  (xfer_done),
    .xfer_rx    (xfer_rx)
  );

endmodule

// File: rtl/flash_window_seq_chk.sv
module flash_window_seq_chk #(
  parameter int NCS = 5,
  parameter int AW  = 32,
  parameter int CSW = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_window,
  input logic           req_write,
  input logic [CSW-1:0] req_cs,
  input logic [AW-1:0]  req_addr,
  input logic [31:0]    req_wdata,
  input logic           req_ready,
  input logic           xfer_go,
  input logic [NCS-1:0] cs_n,
  input logic [NCS-1:0] perm_vec,
  input logic           seq_framed,
  input logic [CSW-1:0] seq_sel
);

  AST_GO_PULSE: assert property (@(posedge clk) disable iff (rst)
    xfer_go |=> !xfer_go); // R11

  AST_READY_PULSE: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready); // R10

  AST_READY_NOT_WITH_GO: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !xfer_go); // R10

  AST_WRITE_NEEDS_PERM: assert property (@(posedge clk) disable iff (rst)
    (xfer_go && req_valid && req_window && req_write) |-> ((perm_vec >> req_cs) & NCS'(1)) != '0); // R8

  AST_SEL_LOW_WHILE_FRAMED: assert property (@(posedge clk) disable iff (rst)
    (xfer_go && seq_framed) |-> ((cs_n >> seq_sel) & NCS'(1)) == '0); // R3

  for (genvar i = 0; i < NCS; i++) begin : g_rel
    AST_REL_BIT_DRIVES_LINE: assert property (@(posedge clk) disable iff (rst)
      (req_ready && req_valid && !req_window && req_write && req_addr[7:2] == 6'(4 + i))
        |-> cs_n[i] == req_wdata[2]); // R7
  end

endmodule

bind flash_window_seq flash_window_seq_chk #(.NCS(NCS), .AW(AW), .CSW(CSW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_window (req_window),
  .req_write  (req_write),
  .req_cs     (req_cs),
  .req_addr   (req_addr),
  .req_wdata  (req_wdata),
  .req_ready  (req_ready),
  .xfer_go    (xfer_go),
  .cs_n       (cs_n),
  .perm_vec   (perm_vec),
  .seq_framed (seq_framed),
  .seq_sel    (seq_sel)
);

// File: tb/flash_window_seq_tb.sv
module flash_window_seq_tb;

  localparam int NCS = 5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           req_valid = 1'b0;
  logic           req_window = 1'b0;
  logic           req_write = 1'b0;
  logic [2:0]     req_cs = '0;
  logic [1:0]     req_size = '0;
  logic [31:0]    req_addr = '0;
  logic [31:0]    req_wdata = '0;
  logic           req_ready;
  logic [31:0]    req_rdata;
  logic           xfer_go;
  logic [7:0]     xfer_tx;
  logic           xfer_done = 1'b0;
  logic [7:0]     xfer_rx = '0;
  logic [NCS-1:0] cs_n;

  int tests = 0;
  int fails = 0;
  int nlog = 0;
  int cur_cs = 0;
  logic [7:0] log_tx [16];
  logic       log_cs [16];
  logic [NCS-1:0] csn_at_ready;

  always #2 clk = ~clk;

  flash_window_seq #(.NCS(NCS), .AW(32)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_window(req_window),
    .req_write(req_write), .req_cs(req_cs), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .req_rdata(req_rdata), .xfer_go(xfer_go), .xfer_tx(xfer_tx),
    .xfer_done(xfer_done), .xfer_rx(xfer_rx), .cs_n(cs_n)
  );

  typedef struct packed {
    logic [2:0]  cs;
    logic        wr;
    logic [1:0]  szm1;
    logic [1:0]  mode;
    logic [7:0]  op;
    logic        ext;
    logic        we;
    logic [31:0] addr;
    logic [31:0] wdata;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 1'b0, 2'd3, 2'd0, 8'hEB, 1'b0, 1'b0, 32'h0012_3456, 32'h0000_0000},
    '{3'd1, 1'b0, 2'd1, 2'd1, 8'h0B, 1'b1, 1'b0, 32'h01AB_CDEF, 32'h0000_0000},
    '{3'd2, 1'b1, 2'd2, 2'd2, 8'h02, 1'b0, 1'b1, 32'h00FE_DCBA, 32'h00C0_FFEE},
    '{3'd3, 1'b1, 2'd0, 2'd2, 8'h12, 1'b1, 1'b1, 32'h7F00_0001, 32'h0000_005A},
    '{3'd2, 1'b1, 2'd3, 2'd2, 8'h02, 1'b0, 1'b0, 32'h0000_1000, 32'hDEAD_BEEF},
    '{3'd0, 1'b1, 2'd3, 2'd0, 8'h03, 1'b0, 1'b1, 32'h0000_2000, 32'h1234_5678},
    '{3'd1, 1'b1, 2'd1, 2'd1, 8'h0B, 1'b1, 1'b1, 32'h0000_3000, 32'h0000_BEEF},
    '{3'd4, 1'b0, 2'd3, 2'd2, 8'h02, 1'b0, 1'b1, 32'h0000_4000, 32'h0000_0000},
    '{3'd4, 1'b1, 2'd3, 2'd3, 8'h00, 1'b0, 1'b1, 32'h0000_5000, 32'h1122_3344},
    '{3'd3, 1'b0, 2'd2, 2'd3, 8'h00, 1'b1, 1'b0, 32'h0000_6000, 32'h0000_0000},
    '{3'd0, 1'b1, 2'd1, 2'd3, 8'h00, 1'b0, 1'b0, 32'h0000_7000, 32'h0000_A5A5}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic win, input logic wr, input logic [2:0] cs,
                     input logic [1:0] szm1, input logic [31:0] addr,
                     input logic [31:0] wdata, output logic [31:0] rd);
    @(negedge clk);
    nlog = 0;
    cur_cs = int'(cs);
    req_window = win; req_write = wr; req_cs = cs; req_size = szm1;
    req_addr = addr; req_wdata = wdata; req_valid = 1'b1;
    do @(negedge clk); while (!req_ready);
    rd = req_rdata;
    csn_at_ready = cs_n;
    req_valid = 1'b0;
  endtask

  task automatic reg_wr(input int off, input logic [31:0] val);
    logic [31:0] dummy;
    bus(1'b0, 1'b1, 3'd0, 2'd3, 32'(off), val, dummy);
  endtask

  task automatic reg_rd(input int off, output logic [31:0] val);
    bus(1'b0, 1'b0, 3'd0, 2'd3, 32'(off), 32'h0, val);
  endtask

  // byte-level SPI shifter model: returns 0xA0 + byte index
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_done) begin
        xfer_done = 1'b0;
      end else if (xfer_go) begin
        if (nlog < 16) begin
          log_tx[nlog] = xfer_tx;
          log_cs[nlog] = cs_n[cur_cs];
        end
        xfer_rx = 8'hA0 + 8'(nlog);
        nlog++;
        xfer_done = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    chk("R1 cs_n after reset", 32'(cs_n), 32'h1F);
    reg_rd(32'h10, rd); chk("R1 ctrl0 reset value", rd, 32'h4);
    reg_rd(32'h20, rd); chk("R1 ctrl4 reset value", rd, 32'h4);
    reg_rd(32'h00, rd); chk("R1 permission word reset", rd, 32'h0);
    reg_rd(32'h04, rd); chk("R1 address-length word reset", rd, 32'h0);

    // R7: release bit drives the select line directly
    reg_wr(32'h14, 32'h0000_0000);
    chk("R7 release bit cleared lowers cs_n[1] only", 32'(csn_at_ready), 32'h1D);
    reg_wr(32'h14, 32'h0000_0004);
    chk("R7 release bit set raises cs_n[1]", 32'(cs_n), 32'h1F);

    for (int v = 0; v < NV; v++) begin
      vec_t t;
      bit ok, framed;
      int hl, n;
      logic [7:0] e [16];
      logic [31:0] exp_rd;
      t = VECS[v];
      // R2, R4, R8: program this select
      reg_wr(32'h00, 32'(t.we) << (16 + int'(t.cs)));
      reg_wr(32'h04, 32'(t.ext) << int'(t.cs));
      reg_wr(32'h10 + 4 * int'(t.cs),
             {8'h00, t.op, 13'h0, (t.mode != 2'd3), t.mode});
      if (t.mode == 2'd3) begin
        ok = !(t.wr && !t.we);
        framed = 1'b0;
      end else if (t.wr) begin
        ok = (t.mode == 2'd2) && t.we;
        framed = 1'b1;
      end else begin
        ok = (t.mode != 2'd2);
        framed = 1'b1;
      end
      hl = framed ? (t.ext ? 5 : 4) : 0;
      n  = ok ? hl + int'(t.szm1) + 1 : 0;
      for (int i = 0; i < 16; i++) e[i] = 8'h00;
      if (framed) begin
        e[0] = (t.mode == 2'd0) ? 8'h03 : t.op;
        for (int j = 0; j < hl - 1; j++) e[1 + j] = 8'(t.addr >> (8 * (hl - 2 - j)));
      end
      exp_rd = '0;
      for (int d = 0; d <= int'(t.szm1); d++) begin
        e[hl + d] = t.wr ? 8'(t.wdata >> (8 * d)) : 8'h00;
        if (ok && !t.wr) exp_rd[8 * d +: 8] = 8'hA0 + 8'(hl + d);
      end

      bus(1'b1, t.wr, t.cs, t.szm1, t.addr, t.wdata, rd);
      // R8, R9: dropped/refused send nothing; R3/R4/R6: byte count
      chk($sformatf("R3 R4 R6 R8 R9 vec%0d byte count", v), 32'(nlog), 32'(n));
      for (int i = 0; i < n && i < 16; i++) begin
        chk($sformatf("R2 R3 R5 R6 vec%0d byte %0d", v, i), 32'(log_tx[i]), 32'(e[i]));
        chk($sformatf("R3 R6 vec%0d select low at byte %0d", v, i), 32'(log_cs[i]), 32'h0);
      end
      // R5, R6, R10: read data assembly and zero on refusal
      chk($sformatf("R5 R10 vec%0d read data", v), rd, exp_rd);
      // R10: framed access releases select before ready; R6: raw leaves it
      chk($sformatf("R6 R10 vec%0d select at ready", v),
          32'(csn_at_ready[t.cs]), (t.mode == 2'd3) ? 32'h0 : 32'h1);
      if (t.mode == 2'd3) begin
        reg_wr(32'h10 + 4 * int'(t.cs), 32'h0000_0007);
        chk($sformatf("R7 vec%0d release restored", v), 32'(cs_n), 32'h1F);
      end
    end

    // R2: read-back of opcode field from a control word
    reg_wr(32'h18, 32'h00AB_0005);
    reg_rd(32'h18, rd);
    chk("R2 control word read-back", rd, 32'h00AB_0005);
    // R4: address-length word read-back
    reg_wr(32'h04, 32'h0000_0015);
    reg_rd(32'h04, rd);
    chk("R4 address-length read-back", rd, 32'h15);
    // R11: after the last access the shifter sees no stray byte
    repeat (5) @(negedge clk);
    chk("R11 no byte issued while idle", 32'(xfer_go), 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule